// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Strobe Sequencer

This block keeps a DRAM's contents alive. After reset it holds the strobes idle for a power-up pause, then runs a fixed burst of initialization refreshes on its own and raises a ready flag. From then on an interval timer adds one owed refresh per period to a saturating debt counter. While debt is owed, the block asks the access controller for the bus. When the bus is granted, the block plays out the owed refreshes back to back and takes priority over new accesses until the debt is cleared.

Each refresh is one of two kinds, chosen once while reset is held. In the internal-counter kind, the column strobe falls first and the row strobe follows, so the device steps its own row counter. In the addressed kind, only the row strobe pulses while a local row counter drives the address bus; that counter advances after every such refresh. The write-enable line is held high at all times, so the column-first ordering can never be taken as a test-mode entry.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: For PAUSE_CYC cycles after reset is released, both strobes stay high (inactive) and `init_done_o` and `req_o` stay low. `req_o` is never high while `init_done_o` is low.
- R2: After the pause, exactly INIT_REFRESHES refresh cycles are issued without waiting for `grant_i`. `init_done_o` then rises and stays high until the next reset.
- R3: In internal-counter mode (`ras_only_mode_i`=0 at reset), `cas_n_o` is low for at least CSR_CYC cycles before each fall of `ras_n_o` and stays low while `ras_n_o` is low. `we_n_o` is always 1.
- R4: In addressed mode (`ras_only_mode_i`=1 at reset), `cas_n_o` stays high at all times. `row_addr_en_o` is 1 whenever `ras_n_o` is low.
- R5: In addressed mode, `row_addr_o` starts at 0 after reset and advances by one after each refresh. It wraps from 2^ROW_W-1 to 0, and the initialization refreshes are counted.
- R6: `ras_n_o` is low for exactly RAS_CYC cycles per refresh, and it is high for at least RP_CYC cycles between two refreshes.
- R7: Once ready, one refresh becomes owed every INTERVAL_CYC cycles. The owed count saturates at DEBT_MAX, so a longer wait yields no more than DEBT_MAX refreshes.
- R8: `req_o` is high while any refresh is owed or one is in progress. No refresh starts while `grant_i` is low. With `grant_i` held high, all owed refreshes run back to back, and `req_o` falls after the last precharge.
- R9: `ras_only_mode_i` is sampled only while `rst` is high. Changes to it afterwards have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode_i | input | 1 | Refresh kind, sampled in reset: 1 = addressed, 0 = internal counter |
| grant_i | input | 1 | Access controller hands the bus to the refresh path |
| req_o | output | 1 | Refresh path needs or holds the bus |
| init_done_o | output | 1 | Pause and initialization burst complete |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| row_addr_en_o | output | 1 | Drive `row_addr_o` onto the address bus |
| row_addr_o | output | ROW_W | Row address for addressed refresh |

## Verification
The bench shrinks the timing to a 20-cycle pause, a 64-cycle refresh interval, a debt cap of 3 and a 4-bit row counter. It keeps the strobe widths at 2, 3 and 2 cycles. With these values, debt saturation is reached after a few withheld intervals, and the row counter wraps within one addressed run of about twenty refreshes. The short pause and interval also keep both refresh kinds, with the mode input toggled after reset, within a few thousand cycles.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_PRECH
    } seq_phase_t;

    typedef enum logic [1:0] {
        CT_PAUSE,
        CT_INIT,
        CT_RUN
    } ctrl_state_t;

    typedef enum logic {
        REF_CBR     = 1'b0,
        REF_RASONLY = 1'b1
    } ref_kind_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic addr_en;
    } strobe_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import dram_refresh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 12500,
    parameter int unsigned INTERVAL_CYC = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic pause_i,
    input  logic run_i,
    output logic pause_done_o,
    output logic tick_o
);
    localparam int unsigned TW = $clog2(max2(PAUSE_CYC, INTERVAL_CYC) + 1);

    logic [TW-1:0] cnt_q;

    assign pause_done_o = pause_i && (cnt_q == TW'(PAUSE_CYC - 1));
    assign tick_o       = run_i && (cnt_q == TW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (pause_done_o || tick_o || !(pause_i || run_i)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
    parameter int unsigned DEBT_MAX = 8,
    localparam int unsigned DW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          take_i,
    output logic [DW-1:0] debt_o,
    output logic          owed_o
);
    logic [DW:0] sum;

    always_comb begin
        sum = {1'b0, debt_o} + (DW+1)'(tick_i) - (DW+1)'(take_i);
        if (sum > (DW+1)'(DEBT_MAX)) begin
            sum = (DW+1)'(DEBT_MAX);
        end
    end

    assign owed_o = (debt_o != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_o <= '0;
        end else begin
            debt_o <= sum[DW-1:0];
        end
    end
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int unsigned CSR_CYC = 2,
    parameter int unsigned RAS_CYC = 8,
    parameter int unsigned RP_CYC  = 5,
    parameter int unsigned ROW_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  ref_kind_t        kind_i,
    output strobe_t          strobe_o,
    output logic [ROW_W-1:0] row_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int unsigned CW = $clog2(max2(max2(CSR_CYC, RAS_CYC), RP_CYC) + 1);

    seq_phase_t    phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          phase_end;

    always_comb begin
        case (phase_q)
            PH_SETUP:  last = CW'(CSR_CYC - 1);
            PH_STROBE: last = CW'(RAS_CYC - 1);
            PH_PRECH:  last = CW'(RP_CYC - 1);
            default:   last = '0;
        endcase
    end

    assign phase_end = (phase_q != PH_IDLE) && (cnt_q == last);
    assign busy_o    = (phase_q != PH_IDLE);
    assign done_o    = (phase_q == PH_PRECH) && phase_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            row_o   <= '0;
        end else if (phase_q == PH_IDLE) begin
            cnt_q <= '0;
            if (start_i) begin
                phase_q <= PH_SETUP;
            end
        end else if (phase_end) begin
            cnt_q <= '0;
            case (phase_q)
                PH_SETUP:  phase_q <= PH_STROBE;
                PH_STROBE: phase_q <= PH_PRECH;
                default:   phase_q <= PH_IDLE;
            endcase
            if (phase_q == PH_STROBE && kind_i == REF_RASONLY) begin
                row_o <= row_o + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        strobe_o.ras_n   = (phase_q != PH_STROBE);
        strobe_o.cas_n   = !((kind_i == REF_CBR) &&
                             (phase_q == PH_SETUP || phase_q == PH_STROBE));
        strobe_o.we_n    = 1'b1;
        strobe_o.addr_en = (kind_i == REF_RASONLY) &&
                           (phase_q == PH_SETUP || phase_q == PH_STROBE);
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_refresh_pkg::*;
#(
    parameter int unsigned ROW_W          = 10,
    parameter int unsigned PAUSE_CYC      = 12500,
    parameter int unsigned INTERVAL_CYC   = 1950,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned DEBT_MAX       = 8,
    parameter int unsigned CSR_CYC        = 2,
    parameter int unsigned RAS_CYC        = 8,
    parameter int unsigned RP_CYC         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_only_mode_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic             init_done_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic             row_addr_en_o,
    output logic [ROW_W-1:0] row_addr_o
);
    localparam int unsigned IW = $clog2(INIT_REFRESHES + 1);
    localparam int unsigned DW = $clog2(DEBT_MAX + 1);

    ctrl_state_t   state_q;
    ref_kind_t     kind_q;
    logic [IW-1:0] init_cnt_q;
    logic [DW-1:0] debt_q;
    logic          pause_done, tick, owed, take, start;
    logic          seq_busy, seq_done;
    strobe_t       strobe;

    refresh_interval_timer #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INTERVAL_CYC(INTERVAL_CYC)
    ) timer_i (
        .clk         (clk),
        .rst         (rst),
        .pause_i     (state_q == CT_PAUSE),
        .run_i       (state_q == CT_RUN),
        .pause_done_o(pause_done),
        .tick_o      (tick)
    );

    refresh_debt #(
        .DEBT_MAX(DEBT_MAX)
    ) debt_i (
        .clk   (clk),
        .rst   (rst),
        .tick_i(tick),
        .take_i(take),
        .debt_o(debt_q),
        .owed_o(owed)
    );

    refresh_seq #(
        .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC),
        .ROW_W  (ROW_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .kind_i  (kind_q),
        .strobe_o(strobe),
        .row_o   (row_addr_o),
        .busy_o  (seq_busy),
        .done_o  (seq_done)
    );

    assign take  = (state_q == CT_RUN) && owed && grant_i && !seq_busy;
    assign start = take || ((state_q == CT_INIT) && !seq_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CT_PAUSE;
            kind_q     <= ras_only_mode_i ? REF_RASONLY : REF_CBR;
            init_cnt_q <= '0;
        end else begin
            case (state_q)
                CT_PAUSE: if (pause_done) state_q <= CT_INIT;
                CT_INIT: begin
                    if (seq_done) begin
                        if (init_cnt_q == IW'(INIT_REFRESHES - 1)) begin
                            state_q <= CT_RUN;
                        end else begin
                            init_cnt_q <= init_cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= CT_RUN;
            endcase
        end
    end

    assign init_done_o   = (state_q == CT_RUN);
    assign req_o         = init_done_o && (owed || seq_busy);
    assign ras_n_o       = strobe.ras_n;
    assign cas_n_o       = strobe.cas_n;
    assign we_n_o        = strobe.we_n;
    assign row_addr_en_o = strobe.addr_en;
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
    parameter int unsigned ROW_W    = 10,
    parameter int unsigned DEBT_MAX = 8,
    localparam int unsigned DW = $clog2(DEBT_MAX + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             addr_en,
    input logic [ROW_W-1:0] row,
    input logic             req,
    input logic             init_done,
    input logic             grant,
    input logic             ras_only,
    input logic             seq_busy,
    input logic [DW-1:0]    debt
);
    assert_no_req_before_init_R1: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !req);

    assert_cbr_cas_held_R3: assert property (@(posedge clk) disable iff (rst)
        (!ras_only && !ras_n) |-> !cas_n);

    assert_cbr_cas_leads_R3: assert property (@(posedge clk) disable iff (rst)
        (!ras_only && $fell(ras_n)) |-> $past(!cas_n));

    assert_rasonly_cas_idle_R4: assert property (@(posedge clk) disable iff (rst)
        ras_only |-> cas_n);

    assert_rasonly_addr_driven_R4: assert property (@(posedge clk) disable iff (rst)
        (ras_only && !ras_n) |-> addr_en);

    assert_row_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ras_only && $rose(ras_n)) |-> (row == ROW_W'($past(row) + 1'b1)));

    assert_debt_cap_R7: assert property (@(posedge clk) disable iff (rst)
        debt <= DW'(DEBT_MAX));

    assert_start_needs_grant_R8: assert property (@(posedge clk) disable iff (rst)
        (init_done && $past(init_done) && $rose(seq_busy)) |-> $past(grant));
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(
    .ROW_W   (ROW_W),
    .DEBT_MAX(DEBT_MAX)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n_o),
    .cas_n    (cas_n_o),
    .addr_en  (row_addr_en_o),
    .row      (row_addr_o),
    .req      (req_o),
    .init_done(init_done_o),
    .grant    (grant_i),
    .ras_only (kind_q == dram_refresh_pkg::REF_RASONLY),
    .seq_busy (seq_busy),
    .debt     (debt_q)
);

// File: tb/dram_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb_top;
    localparam int unsigned ROW_W    = 4;
    localparam int unsigned PAUSE    = 20;
    localparam int unsigned INTERVAL = 64;
    localparam int unsigned INIT_N   = 8;
    localparam int unsigned DMAX     = 3;
    localparam int unsigned CSR      = 2;
    localparam int unsigned RASW     = 3;
    localparam int unsigned RP       = 2;

    localparam int unsigned VEC_N = 5;
    localparam int unsigned HOLD_K  [VEC_N] = '{1, 2, 3, 4, 6};
    localparam int unsigned EXP_PULS[VEC_N] = '{1, 2, 3, 3, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_i = 1'b0;
    logic grant = 1'b0;
    logic req, init_done, ras_n, cas_n, we_n, addr_en;
    logic [ROW_W-1:0] row;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit ras_only_run = 0;
    int pulses = 0;
    int cyc = 0;
    int exp_row = 0;
    int cas_low_run = 0;
    int ras_low_run = 0;
    int ras_high_run = 100;
    logic prev_ras = 1'b1;

    always #4 clk = ~clk;

    dram_refresh_ctrl #(
        .ROW_W(ROW_W), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL),
        .INIT_REFRESHES(INIT_N), .DEBT_MAX(DMAX),
        .CSR_CYC(CSR), .RAS_CYC(RASW), .RP_CYC(RP)
    ) dut_i (
        .clk(clk), .rst(rst), .ras_only_mode_i(mode_i), .grant_i(grant),
        .req_o(req), .init_done_o(init_done), .ras_n_o(ras_n), .cas_n_o(cas_n),
        .we_n_o(we_n), .row_addr_en_o(addr_en), .row_addr_o(row)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            pulses = 0; cyc = 0; exp_row = 0;
            cas_low_run = 0; ras_low_run = 0; ras_high_run = 100; prev_ras = 1'b1;
        end else begin
            cyc = init_done ? cyc + 1 : 0;
            if (we_n !== 1'b1) check(0, "R3 we_n high", int'(we_n), 1);
            if (ras_only_run && cas_n !== 1'b1) check(0, "R4 cas_n idle", int'(cas_n), 1);
            if (prev_ras && !ras_n) begin
                pulses++;
                check(ras_high_run >= int'(RP), "R6 precharge width", ras_high_run, RP);
                if (ras_only_run) begin
                    check(addr_en == 1'b1, "R4 row address driven", int'(addr_en), 1);
                    check(int'(row) == exp_row, "R5 row address", int'(row), exp_row);
                    exp_row = (exp_row + 1) % (1 << ROW_W);
                end else begin
                    check(cas_low_run >= int'(CSR), "R3 cas lead", cas_low_run, CSR);
                end
                ras_low_run = 0;
            end
            if (!prev_ras && ras_n) begin
                check(ras_low_run == int'(RASW), "R6 ras low width", ras_low_run, RASW);
                ras_high_run = 0;
            end
            if (!ras_n) begin
                ras_low_run++;
                if (!ras_only_run && cas_n) check(0, "R3 cas held low", int'(cas_n), 0);
            end else begin
                ras_high_run++;
            end
            cas_low_run = cas_n ? 0 : cas_low_run + 1;
            prev_ras = ras_n;
        end
    end

    task automatic run_mode(input bit rasonly);
        int p0;
        int p1;
        int guard;
        rst = 1'b1;
        mode_i = rasonly;
        grant = 1'b0;
        ras_only_run = rasonly;
        repeat (3) @(negedge clk);
        check(ras_n && cas_n && !req && !init_done, "R1 reset state",
              int'({ras_n, cas_n, req, init_done}), 4'b1100);
        rst = 1'b0;
        @(negedge clk);
        mode_i = !rasonly;  // R9: change after reset must be ignored
        for (int i = 0; i < int'(PAUSE) - 2; i++) begin
            @(negedge clk);
            if (ras_n !== 1'b1 || cas_n !== 1'b1 || init_done || req)
                check(0, "R1 pause idle", int'({ras_n, cas_n, init_done, req}), 4'b1100);
        end
        check(pulses == 0 && !init_done, "R1 pause complete", pulses, 0);
        guard = 0;
        while (!init_done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        check(init_done == 1'b1, "R2 ready raised", int'(init_done), 1);
        check(pulses == int'(INIT_N), "R2 init burst count", pulses, INIT_N);
        check(req == 1'b0, "R8 no request at ready", int'(req), 0);
        for (int v = 0; v < int'(VEC_N); v++) begin
            p0 = pulses;
            @(negedge clk);
            while (!(cyc % int'(INTERVAL) == int'(INTERVAL) / 2 && cyc >= int'(INTERVAL) + int'(INTERVAL) / 2))
                @(negedge clk);
            repeat ((HOLD_K[v] - 1) * INTERVAL) @(negedge clk);
            check(pulses == p0, "R8 no refresh without grant", pulses - p0, 0);
            check(req == 1'b1, "R8 request while owed", int'(req), 1);
            check(init_done == 1'b1, "R2 ready holds", int'(init_done), 1);
            grant = 1'b1;
            p1 = pulses;
            guard = 0;
            @(negedge clk);
            while (req && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            grant = 1'b0;
            check(pulses - p1 == int'(EXP_PULS[v]), "R7 owed refreshes served",
                  pulses - p1, EXP_PULS[v]);
        end
        if (rasonly)
            check(pulses > (1 << ROW_W), "R5 row wrap reached", pulses, (1 << ROW_W) + 1);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule